// File: doc/BRIEF.md
# Paired-Single Lane Permute and Move Unit

This block is a single-cycle datapath that treats each 64-bit operand as a pair of single-precision values: the upper lane sits in bits 63:32 and the lower lane in bits 31:0. It carries out the operations on such pairs that need no arithmetic:

- lane shuffles between two sources
- whole-pair copy, and sign-bit clearing or inversion in each lane
- moves gated by a zero test on a general register
- per-lane moves gated by floating-point condition-code bits
- a realignment of two sources by a byte offset, which depends on byte order

An issuing pipeline presents two sources (`src_a` is the first source, `src_b` the second), the old destination value, a general-register value, the condition-code vector and an opcode. It then raises `in_valid` for one cycle. The selected result is captured on that rising edge and appears on `result` from then on. Arithmetic, rounding and exceptions are not handled here.

Top module: `ps_lane_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `result` and `align_err` to zero on the next rising edge.
- R2: Opcodes 0 to 3 take the result's upper lane from `src_a` and its lower lane from `src_b`. Opcode 0 gives {a.lower, b.lower}, 1 gives {a.lower, b.upper}, 2 gives {a.upper, b.lower} and 3 gives {a.upper, b.upper}.
- R3: Opcode 4 copies `src_a`. Opcode 5 clears bits 63 and 31 of `src_a`, and opcode 6 inverts those two bits. All other bits pass unchanged.
- R4: Opcode 7 yields `src_a` when any of the 64 bits of `gpr` is set; otherwise it yields `dst_old`.
- R5: Opcode 8 yields `src_a` when `gpr` is zero; otherwise it yields `dst_old`.
- R6: Opcode 9 gates each lane separately. Bit `cc_vec[cc_sel]` gates the lower lane and bit `cc_vec[(cc_sel+1) mod 8]` gates the upper lane. A lane is copied from `src_a` when its bit is 0 and otherwise keeps `dst_old`.
- R7: Opcode 10 uses the same bit-to-lane gating as R6, but copies a lane when its bit is 1.
- R8: Opcode 11 realigns using offset `gpr[2:0]`; the higher bits of `gpr` are ignored. With offset 0 the result equals `src_a`.
- R9: Opcode 11 with offset 4 gives {a.lower, b.upper} when `big_endian` is 1, and {b.lower, a.upper} when it is 0.
- R10: Opcode 11 with any offset other than 0 or 4 yields zero and sets `align_err`. Any other accepted operation clears `align_err`.
- R11: Opcodes 12 to 15 pass `dst_old` through unchanged.
- R12: While `in_valid` is low, `result` and `align_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the current operation |
| op | input | 4 | Operation code |
| src_a | input | 64 | First source pair |
| src_b | input | 64 | Second source pair |
| dst_old | input | 64 | Previous destination value |
| gpr | input | 64 | General register: zero test and realignment offset |
| cc_vec | input | 8 | Floating-point condition-code bits |
| cc_sel | input | 3 | Index of the condition code gating the lower lane |
| big_endian | input | 1 | Byte order for realignment (1 = big-endian) |
| result | output | 64 | Registered result |
| align_err | output | 1 | Registered flag for an unsupported realignment offset |

## Verification
The bench builds the unit with its defaults: 32-bit lanes, eight condition codes and a 64-bit general register. These values make several corners reachable:

- `cc_sel` = 7, where the upper-lane gate wraps to code 0.
- A general register whose only set bit is above bit 31, which must still count as nonzero.
- Offsets whose high bits are set but whose low three bits are zero, which must still realign as offset 0.

Each lane-gating pattern is run for both polarities, and realignment is run in both byte orders.

// File: rtl/ps_lane_pkg.sv
package ps_lane_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PAIR_LL = 4'd0,
    OP_PAIR_LU = 4'd1,
    OP_PAIR_UL = 4'd2,
    OP_PAIR_UU = 4'd3,
    OP_COPY    = 4'd4,
    OP_SGNCLR  = 4'd5,
    OP_SGNFLP  = 4'd6,
    OP_IFNZ    = 4'd7,
    OP_IFZ     = 4'd8,
    OP_CCFALSE = 4'd9,
    OP_CCTRUE  = 4'd10,
    OP_REALIGN = 4'd11
  } ps_op_e;
endpackage

// File: rtl/ps_lane_select.sv
module ps_lane_select
  import ps_lane_pkg::*;
#(
  parameter int LANE_W = 32,
  localparam int DW = 2 * LANE_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y,
  output logic            hit
);
  logic [LANE_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [DW-1:0]     sclr, sflp;

  assign a_hi = a[DW-1:LANE_W];
  assign a_lo = a[LANE_W-1:0];
  assign b_hi = b[DW-1:LANE_W];
  assign b_lo = b[LANE_W-1:0];

  // Sign handling lane by lane: only the top bit of each lane changes.
  for (genvar g = 0; g < 2; g++) begin : g_sign
    localparam int MSB = g * LANE_W + LANE_W - 1;
    assign sclr[MSB] = 1'b0;
    assign sflp[MSB] = ~a[MSB];
    assign sclr[MSB-1 -: LANE_W-1] = a[MSB-1 -: LANE_W-1];
    assign sflp[MSB-1 -: LANE_W-1] = a[MSB-1 -: LANE_W-1];
  end

  always_comb begin
    hit = 1'b1;
    unique case (ps_op_e'(op))
      OP_PAIR_LL: y = {a_lo, b_lo};
      OP_PAIR_LU: y = {a_lo, b_hi};
      OP_PAIR_UL: y = {a_hi, b_lo};
      OP_PAIR_UU: y = {a_hi, b_hi};
      OP_COPY:    y = a;
      OP_SGNCLR:  y = sclr;
      OP_SGNFLP:  y = sflp;
      default: begin
        y   = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ps_cond_move.sv
module ps_cond_move
  import ps_lane_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int NUM_CC = 8,
  parameter int GPR_W  = 64,
  localparam int DW   = 2 * LANE_W,
  localparam int CC_W = $clog2(NUM_CC)
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     old,
  input  logic [GPR_W-1:0]  gpr,
  input  logic [NUM_CC-1:0] cc_vec,
  input  logic [CC_W-1:0]   cc_sel,
  output logic [DW-1:0]     y,
  output logic              hit
);
  logic [CC_W-1:0] cc_up;
  logic [1:0]      take;   // [1] upper lane, [0] lower lane
  logic [1:0]      cc_pair;

  assign cc_up   = (int'(cc_sel) == NUM_CC - 1) ? '0 : cc_sel + CC_W'(1);
  assign cc_pair = {cc_vec[cc_up], cc_vec[cc_sel]};

  always_comb begin
    hit  = 1'b1;
    take = 2'b00;
    unique case (ps_op_e'(op))
      OP_IFNZ:    take = {2{|gpr}};
      OP_IFZ:     take = {2{~|gpr}};
      OP_CCFALSE: take = ~cc_pair;
      OP_CCTRUE:  take = cc_pair;
      default:    hit  = 1'b0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign y[g*LANE_W +: LANE_W] = take[g] ? a[g*LANE_W +: LANE_W]
                                           : old[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ps_realign.sv
module ps_realign #(
  parameter int LANE_W = 32,
  localparam int DW         = 2 * LANE_W,
  localparam int LANE_BYTES = LANE_W / 8,
  localparam int OFF_W      = $clog2(2 * LANE_BYTES)
) (
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [OFF_W-1:0] off,
  input  logic             big_endian,
  output logic [DW-1:0]    y,
  output logic             err
);
  logic [LANE_W-1:0] a_hi, a_lo, b_hi, b_lo;

  assign a_hi = a[DW-1:LANE_W];
  assign a_lo = a[LANE_W-1:0];
  assign b_hi = b[DW-1:LANE_W];
  assign b_lo = b[LANE_W-1:0];

  always_comb begin
    err = 1'b0;
    if (off == '0) begin
      y = a;
    end else if (off == OFF_W'(LANE_BYTES)) begin
      y = big_endian ? {a_lo, b_hi} : {b_lo, a_hi};
    end else begin
      y   = '0;
      err = 1'b1;
    end
  end
endmodule

// File: rtl/ps_lane_unit.sv
module ps_lane_unit
  import ps_lane_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int NUM_CC = 8,
  parameter int GPR_W  = 64,
  localparam int DW    = 2 * LANE_W,
  localparam int CC_W  = $clog2(NUM_CC),
  localparam int OFF_W = $clog2(2 * (LANE_W / 8))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [DW-1:0]     src_a,
  input  logic [DW-1:0]     src_b,
  input  logic [DW-1:0]     dst_old,
  input  logic [GPR_W-1:0]  gpr,
  input  logic [NUM_CC-1:0] cc_vec,
  input  logic [CC_W-1:0]   cc_sel,
  input  logic              big_endian,
  output logic [DW-1:0]     result,
  output logic              align_err
);
  logic [DW-1:0] sel_y, cm_y, rl_y, nxt_res;
  logic          sel_hit, cm_hit, rl_err, nxt_err, is_realign;

  ps_lane_select #(.LANE_W(LANE_W)) u_sel (
    .op(op), .a(src_a), .b(src_b), .y(sel_y), .hit(sel_hit)
  );

  ps_cond_move #(.LANE_W(LANE_W), .NUM_CC(NUM_CC), .GPR_W(GPR_W)) u_cmov (
    .op(op), .a(src_a), .old(dst_old), .gpr(gpr), .cc_vec(cc_vec),
    .cc_sel(cc_sel), .y(cm_y), .hit(cm_hit)
  );

  ps_realign #(.LANE_W(LANE_W)) u_aln (
    .a(src_a), .b(src_b), .off(gpr[OFF_W-1:0]), .big_endian(big_endian),
    .y(rl_y), .err(rl_err)
  );

  assign is_realign = (op == OP_REALIGN);

  always_comb begin
    if (sel_hit)         nxt_res = sel_y;
    else if (cm_hit)     nxt_res = cm_y;
    else if (is_realign) nxt_res = rl_y;
    else                 nxt_res = dst_old;
    nxt_err = is_realign & rl_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      align_err <= 1'b0;
    end else if (in_valid) begin
      result    <= nxt_res;
      align_err <= nxt_err;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !align_err));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(align_err)));

  // R3
  sign_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SGNCLR) |=> (!result[DW-1] && !result[LANE_W-1]));

  // R4
  nz_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_IFNZ && gpr == '0) |=> (result == $past(dst_old)));

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |-> (result == '0));

  // R11
  unknown_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > OP_REALIGN) |=> (result == $past(dst_old)));
endmodule

// File: tb/tb_ps_lane_unit.sv
module tb_ps_lane_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] src_a, src_b, dst_old, gpr;
  logic [7:0]  cc_vec;
  logic [2:0]  cc_sel;
  logic        big_endian;
  logic [63:0] result;
  logic        align_err;

  int n_chk = 0;
  int n_bad = 0;

  // {4.0, 16.0}, {-1.0, 2.0}, {17.0, -8.0}
  localparam logic [63:0] PA = 64'h40800000_41800000;
  localparam logic [63:0] PB = 64'hBF800000_40000000;
  localparam logic [63:0] PC = 64'h41880000_C1000000;
  // {-21.0, 40.0}, {-42.0, 20.0}
  localparam logic [63:0] Q0 = 64'hC1A80000_42200000;
  localparam logic [63:0] Q1 = 64'hC2280000_41A00000;

  always #4 clk = ~clk;

  ps_lane_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src_a(src_a),
    .src_b(src_b), .dst_old(dst_old), .gpr(gpr), .cc_vec(cc_vec),
    .cc_sel(cc_sel), .big_endian(big_endian), .result(result),
    .align_err(align_err)
  );

  task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Drive at negedge, capture at posedge, sample at the next negedge.
  task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] old, input logic [63:0] g, input logic [7:0] ccv,
                       input logic [2:0] ccs, input logic be);
    @(negedge clk);
    op = o; src_a = a; src_b = b; dst_old = old; gpr = g;
    cc_vec = ccv; cc_sel = ccs; big_endian = be; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check64("R1 result after reset", result, 64'h0);
    check1("R1 align_err after reset", align_err, 1'b0);
  endtask

  task automatic t_pairs();
    issue(4'd0, PA, PB, PC, 0, 0, 0, 0); check64("R2 lower/lower", result, 64'h41800000_40000000);
    issue(4'd1, PA, PB, PC, 0, 0, 0, 0); check64("R2 lower/upper", result, 64'h41800000_BF800000);
    issue(4'd2, PA, PB, PC, 0, 0, 0, 0); check64("R2 upper/lower", result, 64'h40800000_40000000);
    issue(4'd3, PA, PB, PC, 0, 0, 0, 0); check64("R2 upper/upper", result, 64'h40800000_BF800000);
  endtask

  task automatic t_sign();
    issue(4'd4, PB, PA, PC, 0, 0, 0, 0); check64("R3 copy", result, PB);
    issue(4'd5, PB, PA, PC, 0, 0, 0, 0); check64("R3 sign clear", result, 64'h3F800000_40000000);
    issue(4'd6, PB, PA, PC, 0, 0, 0, 0); check64("R3 sign invert", result, 64'h3F800000_C0000000);
  endtask

  task automatic t_gpr_moves();
    issue(4'd7, PB, PC, PA, 64'd0, 0, 0, 0); check64("R4 nonzero-move gpr=0", result, PA);
    issue(4'd7, PB, PC, PA, 64'd1, 0, 0, 0); check64("R4 nonzero-move gpr=1", result, PB);
    issue(4'd7, PB, PC, PA, 64'h80000000_00000000, 0, 0, 0);
    check64("R4 nonzero-move high bit only", result, PB);
    issue(4'd8, PB, PC, PA, 64'd0, 0, 0, 0); check64("R5 zero-move gpr=0", result, PB);
    issue(4'd8, PB, PC, PA, 64'd1, 0, 0, 0); check64("R5 zero-move gpr=1", result, PA);
  endtask

  task automatic t_cc_false();
    issue(4'd9, PB, PC, PA, 0, 8'b00, 3'd0, 0); check64("R6 both clear", result, PB);
    issue(4'd9, PB, PC, PA, 0, 8'b01, 3'd0, 0); check64("R6 lower set", result, 64'hBF800000_41800000);
    issue(4'd9, PB, PC, PA, 0, 8'b10, 3'd0, 0); check64("R6 upper set", result, 64'h40800000_40000000);
    issue(4'd9, PB, PC, PA, 0, 8'b11, 3'd0, 0); check64("R6 both set", result, PA);
    issue(4'd9, PB, PC, PA, 0, 8'b0011_0000, 3'd4, 0); check64("R6 cc_sel=4 both set", result, PA);
  endtask

  task automatic t_cc_true();
    issue(4'd10, PB, PC, PA, 0, 8'b00, 3'd0, 0); check64("R7 both clear", result, PA);
    issue(4'd10, PB, PC, PA, 0, 8'b01, 3'd0, 0); check64("R7 lower set", result, 64'h40800000_40000000);
    issue(4'd10, PB, PC, PA, 0, 8'b10, 3'd0, 0); check64("R7 upper set", result, 64'hBF800000_41800000);
    issue(4'd10, PB, PC, PA, 0, 8'b11, 3'd0, 0); check64("R7 both set", result, PB);
    // cc_sel = 7: lower gated by bit 7, upper wraps to bit 0
    issue(4'd10, PB, PC, PA, 0, 8'h01, 3'd7, 0); check64("R7 wrap upper", result, 64'hBF800000_41800000);
    issue(4'd10, PB, PC, PA, 0, 8'h80, 3'd7, 0); check64("R7 wrap lower", result, 64'h40800000_40000000);
  endtask

  task automatic t_realign();
    issue(4'd11, Q0, Q1, PA, 64'd0, 0, 0, 1); check64("R8 offset 0", result, Q0);
    check1("R8 no error at offset 0", align_err, 1'b0);
    issue(4'd11, Q0, Q1, PA, 64'hFFF8, 0, 0, 0); check64("R8 high offset bits ignored", result, Q0);
    issue(4'd11, Q0, Q1, PA, 64'd4, 0, 0, 1); check64("R9 offset 4 big-endian", result, 64'h42200000_C2280000);
    issue(4'd11, Q0, Q1, PA, 64'd4, 0, 0, 0); check64("R9 offset 4 little-endian", result, 64'h41A00000_C1A80000);
    check1("R9 no error at offset 4", align_err, 1'b0);
    issue(4'd11, Q0, Q1, PA, 64'd2, 0, 0, 1); check64("R10 offset 2 result", result, 64'h0);
    check1("R10 offset 2 flag", align_err, 1'b1);
    issue(4'd11, Q0, Q1, PA, 64'd7, 0, 0, 0); check1("R10 offset 7 flag", align_err, 1'b1);
    issue(4'd4, PC, PA, PB, 0, 0, 0, 0); check1("R10 flag cleared by other op", align_err, 1'b0);
    check64("R10 result after clearing op", result, PC);
  endtask

  task automatic t_unknown();
    issue(4'd12, PB, PC, PA, 64'd1, 8'hFF, 0, 0); check64("R11 opcode 12", result, PA);
    issue(4'd15, PB, PC, PC, 64'd4, 8'hFF, 0, 1); check64("R11 opcode 15", result, PC);
  endtask

  task automatic t_hold();
    issue(4'd11, Q0, Q1, PA, 64'd3, 0, 0, 0);
    @(negedge clk);
    op = 4'd4; src_a = PB; dst_old = PC; gpr = 64'd0;
    repeat (3) @(negedge clk);
    check64("R12 result held while idle", result, 64'h0);
    check1("R12 flag held while idle", align_err, 1'b1);
    issue(4'd4, PB, PA, PA, 0, 0, 0, 0);
    t_reset();
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
    dst_old = '0; gpr = '0; cc_vec = '0; cc_sel = '0; big_endian = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pairs();
    t_sign();
    t_gpr_moves();
    t_cc_false();
    t_cc_true();
    t_realign();
    t_unknown();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule